// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Buffer

This block caches virtual-to-physical page translations for a processor port. It is direct-mapped. All access classes share one physical-frame array, and each class has its own tag array: one for instruction fetch, one for data load and one for data store. A translation that was filled for loads therefore does not count as a hit for a store or a fetch to the same page. An outside walker performs the page walk and checks permissions.

A lookup presents a virtual address together with two qualifiers, `lk_store` and `lk_fetch`. On a hit the block returns the physical address in the same cycle. On a miss it raises a refill request that carries the same address and qualifiers. The lookup and refill interfaces follow valid/ready rules:
- A lookup is accepted when it hits.
- A lookup that misses is accepted only when the refill request is taken (`rq_ready` high).
- Until the lookup is accepted, the requester holds `lk_vaddr`, `lk_store` and `lk_fetch` stable.

The fill port is a plain single-cycle write and is never back-pressured. The block also holds the page table base register. Any write to that register discards every cached translation.

Top module: `split_tlb`

## Requirements
- R1: After reset every entry of all three tag arrays is invalid, so no lookup hits. The base register reads zero.
- R2: The entry index is virtual address bits [PG_SHIFT+IDX_W-1:PG_SHIFT], with PG_SHIFT=13 (8 KiB pages). Two pages whose page numbers differ by a multiple of ENTRIES share an entry. A fill of one page makes a lookup of the other page miss.
- R3: The tag array is chosen from the qualifiers in this priority order:
  - fetch when `lk_fetch`=1, whatever `lk_store` is;
  - otherwise store when `lk_store`=1;
  - otherwise load.
  The fill port uses the same rule with `fl_fetch` and `fl_store`.
- R4: A lookup hits only if the selected array holds a valid tag equal to the full virtual page number, which is the address with its low 13 bits removed.
- R5: On a hit, `lk_paddr` is the stored frame base, with bits [PA_W-1:13] taken from the fill's `fl_paddr`, OR'd with the lookup's 13-bit page offset. The low 13 bits of `fl_paddr` have no effect.
- R6: On a valid lookup that misses, `rq_valid`=1 and `rq_vaddr`/`rq_store`/`rq_fetch` equal the lookup's inputs. `lk_ready` equals `lk_hit` OR `rq_ready`. A hit never raises `rq_valid`.
- R7: A fill sets the tag and valid bit only in the array of its own access class. The other two classes still miss on that page.
- R8: The frame array is shared across classes. A fill for any class at an index replaces the frame that the other classes return on a hit at that index.
- R9: A write to the base register stores `ptb_wdata` with bits [12:0] forced to zero.
- R10: A base register write invalidates every entry of all three arrays in one cycle. If a fill arrives in the same cycle, the flush wins and the fill leaves no valid entry.
- R11: A lookup in the same cycle as a fill to its index sees the contents from before the fill. The fill becomes visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup accepted (hit, or refill request taken) |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_store | input | 1 | Lookup is a data store |
| lk_fetch | input | 1 | Lookup is an instruction fetch |
| lk_hit | output | 1 | Lookup hit in the selected tag array |
| lk_paddr | output | PA_W | Translated physical address, valid when lk_hit |
| rq_valid | output | 1 | Refill request valid (lookup missed) |
| rq_ready | input | 1 | Walker takes the refill request |
| rq_vaddr | output | VA_W | Refill request virtual address |
| rq_store | output | 1 | Refill request store qualifier |
| rq_fetch | output | 1 | Refill request fetch qualifier |
| fl_valid | input | 1 | Fill write strobe |
| fl_vaddr | input | VA_W | Virtual address being filled |
| fl_store | input | 1 | Fill store qualifier |
| fl_fetch | input | 1 | Fill fetch qualifier |
| fl_paddr | input | PA_W | Frame base of the fill (low 13 bits ignored) |
| ptb_we | input | 1 | Base register write, also flushes all entries |
| ptb_wdata | input | PA_W | Base register write data |
| ptb_q | output | PA_W | Base register contents |

## Verification
The bench targets four failure modes:
- **Aliasing.** Page numbers that differ by exactly the entry count share an entry. A design that compares only index bits, or truncates the tag, would report a false hit on such a page.
- **Qualifier priority and class isolation.** The bench checks that a fetch with the store qualifier also set uses the fetch array. It also checks that a load fill does not open the page to stores or fetches. A design that merged the tag arrays or reversed the priority would hit or miss on the wrong class.
- **Shared frame.** After a fill from another class at the same index, a hit must return the new frame.
- **Same-cycle collisions.** A lookup during a fill must see the old contents. A base write together with a fill must leave nothing valid. A design that forwarded the fill, or let the fill win over the flush, would hit one cycle early or keep a stale entry.

// File: rtl/split_tlb_pkg.sv
package split_tlb_pkg;

  typedef enum logic [1:0] {
    CLS_LOAD  = 2'd0,
    CLS_STORE = 2'd1,
    CLS_FETCH = 2'd2
  } acc_cls_e;

  localparam int unsigned NUM_CLS = 3;

  function automatic acc_cls_e cls_of(input logic store, input logic fetch);
    if (fetch)      return CLS_FETCH;
    else if (store) return CLS_STORE;
    else            return CLS_LOAD;
  endfunction

endpackage

// File: rtl/split_tlb_cls_dec.sv
module split_tlb_cls_dec
  import split_tlb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               store,
  input  logic               fetch,
  output logic [NUM_CLS-1:0] sel
);
  acc_cls_e cls;

  always_comb begin
    cls = cls_of(store, fetch);
    sel = '0;
    sel[cls] = 1'b1;
  end

  a_r3_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == 1);
  a_r3_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> sel[CLS_FETCH]);

endmodule

// File: rtl/split_tlb_tag_bank.sv
module split_tlb_tag_bank #(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned VPN_W   = 19,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic             rd_hit
);
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                vld_q <= '0;
    else if (flush)            vld_q <= '0;
    else if (wr_en)            vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) tag_q[wr_idx] <= wr_vpn;
  end

  assign rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_vpn);

  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
  a_r7_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> vld_q[$past(wr_idx)]);
  a_r7_fill_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> (tag_q[$past(wr_idx)] == $past(wr_vpn)));

endmodule

// File: rtl/split_tlb_frame_store.sv
module split_tlb_frame_store #(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned PFN_W   = 19,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PFN_W-1:0] rd_pfn
);
  logic [PFN_W-1:0] pfn_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) pfn_q[wr_idx] <= wr_pfn;
  end

  assign rd_pfn = pfn_q[rd_idx];

endmodule

// File: rtl/split_tlb.sv
module split_tlb
  import split_tlb_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned PG_SHIFT = 13,
  parameter int unsigned ENTRIES  = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [VA_W-1:0] lk_vaddr,
  input  logic            lk_store,
  input  logic            lk_fetch,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_paddr,
  output logic            rq_valid,
  input  logic            rq_ready,
  output logic [VA_W-1:0] rq_vaddr,
  output logic            rq_store,
  output logic            rq_fetch,
  input  logic            fl_valid,
  input  logic [VA_W-1:0] fl_vaddr,
  input  logic            fl_store,
  input  logic            fl_fetch,
  input  logic [PA_W-1:0] fl_paddr,
  input  logic            ptb_we,
  input  logic [PA_W-1:0] ptb_wdata,
  output logic [PA_W-1:0] ptb_q
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned VPN_W = VA_W - PG_SHIFT;
  localparam int unsigned PFN_W = PA_W - PG_SHIFT;
  localparam logic [PA_W-1:0] OFF_MASK = PA_W'((64'd1 << PG_SHIFT) - 64'd1);

  logic [VPN_W-1:0]   lk_vpn, fl_vpn;
  logic [IDX_W-1:0]   lk_idx, fl_idx;
  logic [NUM_CLS-1:0] lk_sel, fl_sel, cls_hit;
  logic [PFN_W-1:0]   rd_pfn;
  logic               flush, any_hit;
  logic               unused_low;

  assign lk_vpn = lk_vaddr[VA_W-1:PG_SHIFT];
  assign fl_vpn = fl_vaddr[VA_W-1:PG_SHIFT];
  assign lk_idx = lk_vpn[IDX_W-1:0];
  assign fl_idx = fl_vpn[IDX_W-1:0];
  assign flush  = ptb_we;
  assign unused_low = ^{fl_vaddr[PG_SHIFT-1:0], fl_paddr[PG_SHIFT-1:0]};

  split_tlb_cls_dec u_lk_dec (
    .clk(clk), .rst_n(rst_n), .store(lk_store), .fetch(lk_fetch), .sel(lk_sel)
  );
  split_tlb_cls_dec u_fl_dec (
    .clk(clk), .rst_n(rst_n), .store(fl_store), .fetch(fl_fetch), .sel(fl_sel)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_bank
    split_tlb_tag_bank #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .wr_en  (fl_valid && fl_sel[c]),
      .wr_idx (fl_idx),
      .wr_vpn (fl_vpn),
      .rd_idx (lk_idx),
      .rd_vpn (lk_vpn),
      .rd_hit (cls_hit[c])
    );
  end

  split_tlb_frame_store #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_frames (
    .clk    (clk),
    .wr_en  (fl_valid),
    .wr_idx (fl_idx),
    .wr_pfn (fl_paddr[PA_W-1:PG_SHIFT]),
    .rd_idx (lk_idx),
    .rd_pfn (rd_pfn)
  );

  assign any_hit  = |(cls_hit & lk_sel);
  assign lk_hit   = lk_valid && any_hit;
  assign lk_paddr = {rd_pfn, lk_vaddr[PG_SHIFT-1:0]};
  assign rq_valid = lk_valid && !any_hit;
  assign rq_vaddr = lk_vaddr;
  assign rq_store = lk_store;
  assign rq_fetch = lk_fetch;
  assign lk_ready = lk_hit || (rq_valid && rq_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptb_q <= '0;
    else if (ptb_we) ptb_q <= ptb_wdata & ~OFF_MASK;
  end

  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[PG_SHIFT-1:0] == lk_vaddr[PG_SHIFT-1:0]));
  a_r6_hit_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !rq_valid);
  a_r6_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit && !rq_ready) |-> !lk_ready);
  a_r9_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ptb_we |=> (ptb_q == ($past(ptb_wdata) & ~OFF_MASK)));
  a_r10_no_hit_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ptb_we |=> !lk_hit);

endmodule

// File: tb/split_tlb_test.sv
`timescale 1ns/1ps
module split_tlb_test;
  localparam int unsigned ENT = 16;
  localparam int unsigned PGS = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0, lk_store = 0, lk_fetch = 0, rq_ready = 0;
  logic [31:0] lk_vaddr = '0;
  logic        fl_valid = 0, fl_store = 0, fl_fetch = 0, ptb_we = 0;
  logic [31:0] fl_vaddr = '0, fl_paddr = '0, ptb_wdata = '0;
  logic        lk_ready, lk_hit, rq_valid, rq_store, rq_fetch;
  logic [31:0] lk_paddr, rq_vaddr, ptb_q;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  split_tlb #(.VA_W(32), .PA_W(32), .PG_SHIFT(PGS), .ENTRIES(ENT)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
    .lk_store(lk_store), .lk_fetch(lk_fetch), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_vaddr(rq_vaddr),
    .rq_store(rq_store), .rq_fetch(rq_fetch),
    .fl_valid(fl_valid), .fl_vaddr(fl_vaddr), .fl_store(fl_store),
    .fl_fetch(fl_fetch), .fl_paddr(fl_paddr),
    .ptb_we(ptb_we), .ptb_wdata(ptb_wdata), .ptb_q(ptb_q)
  );

  function automatic logic [31:0] va(input int unsigned vpn, input int unsigned off);
    return (vpn << PGS) | (off & 32'h1FFF);
  endfunction
  function automatic logic [31:0] pbase(input int unsigned i);
    return (32'h0005_0000 + i * 32'h131) << PGS;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] a, input logic st, input logic fe);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = a; lk_store = st; lk_fetch = fe;
    #1;
  endtask

  task automatic fill(input logic [31:0] a, input logic st, input logic fe,
                      input logic [31:0] p);
    @(negedge clk);
    fl_valid = 1; fl_vaddr = a; fl_store = st; fl_fetch = fe; fl_paddr = p;
    @(negedge clk);
    fl_valid = 0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] p);
    chk(lk_hit === 1'b1, req, "hit", {31'd0, lk_hit}, 32'd1);
    chk(lk_paddr === p, req, "paddr", lk_paddr, p);
  endtask

  task automatic expect_miss(input string req);
    chk(lk_hit === 1'b0, req, "miss", {31'd0, lk_hit}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    chk(ptb_q === 32'd0, "R1", "ptb", ptb_q, 32'd0);
    for (int i = 0; i < ENT; i++) begin
      for (int c = 0; c < 3; c++) begin
        look(va(32'h100 + i, i * 3), c == 1, c == 2);
        expect_miss("R1");
      end
    end

    // R7 + R5: fill every index for loads; fill low bits carry junk
    for (int i = 0; i < ENT; i++) fill(va(32'h100 + i, 0), 0, 0, pbase(i) | 32'h1ABC);
    for (int i = 0; i < ENT; i++) begin
      for (int off = 0; off < 32'h2000; off += 32'h7F1) begin
        look(va(32'h100 + i, off), 0, 0);
        expect_hit("R5", pbase(i) | off);
      end
      look(va(32'h100 + i, 5), 1, 0); expect_miss("R7");
      look(va(32'h100 + i, 5), 0, 1); expect_miss("R7");
    end

    // R2 / R4: aliasing page (vpn + ENT) misses, other tag bits too
    for (int i = 0; i < ENT; i++) begin
      look(va(32'h100 + i + ENT, 1), 0, 0); expect_miss("R2");
      look(va(32'h100 + i + 32'h40000, 1), 0, 0); expect_miss("R4");
    end

    // R6: miss handshake and request contents
    rq_ready = 0;
    look(va(32'h777, 9), 1, 0);
    chk(rq_valid === 1 && rq_vaddr === va(32'h777, 9) && rq_store === 1 && rq_fetch === 0,
        "R6", "request", rq_vaddr, va(32'h777, 9));
    chk(lk_ready === 0, "R6", "ready stalled", {31'd0, lk_ready}, 32'd0);
    rq_ready = 1; #0.1;
    chk(lk_ready === 1, "R6", "ready taken", {31'd0, lk_ready}, 32'd1);
    rq_ready = 0;
    look(va(32'h103, 4), 0, 0);
    chk(lk_ready === 1 && rq_valid === 0, "R6", "hit no request", {31'd0, rq_valid}, 32'd0);

    // R3: fetch wins over store
    fill(va(32'h105, 0), 1, 1, pbase(40));
    look(va(32'h105, 2), 1, 1); expect_hit("R3", pbase(40) | 2);
    look(va(32'h105, 2), 0, 1); expect_hit("R3", pbase(40) | 2);
    look(va(32'h105, 2), 1, 0); expect_miss("R3");
    // R8: shared frame now returned for load too
    look(va(32'h105, 2), 0, 0); expect_hit("R8", pbase(40) | 2);

    // R11: same-cycle fill and lookup sees old contents
    @(negedge clk);
    fl_valid = 1; fl_vaddr = va(32'h109, 0); fl_store = 1; fl_fetch = 0; fl_paddr = pbase(50);
    lk_valid = 1; lk_vaddr = va(32'h109, 6); lk_store = 1; lk_fetch = 0;
    #1; expect_miss("R11");
    @(negedge clk); fl_valid = 0; #1;
    expect_hit("R11", pbase(50) | 6);

    // R9 / R10: base write flushes all classes
    @(negedge clk); ptb_we = 1; ptb_wdata = 32'hDEAD_BEEF;
    @(negedge clk); ptb_we = 0;
    chk(ptb_q === 32'hDEAD_A000, "R9", "ptb", ptb_q, 32'hDEAD_A000);
    for (int i = 0; i < ENT; i++) begin
      look(va(32'h100 + i, 0), 0, 0); expect_miss("R10");
    end
    look(va(32'h105, 0), 0, 1); expect_miss("R10");
    look(va(32'h109, 0), 1, 0); expect_miss("R10");

    // R10: flush beats a same-cycle fill
    @(negedge clk);
    lk_valid = 0;
    ptb_we = 1; ptb_wdata = 32'h0000_3FFF;
    fl_valid = 1; fl_vaddr = va(32'h10A, 0); fl_store = 0; fl_fetch = 0; fl_paddr = pbase(7);
    @(negedge clk); ptb_we = 0; fl_valid = 0;
    look(va(32'h10A, 0), 0, 0); expect_miss("R10");
    chk(ptb_q === 32'h0000_2000, "R9", "ptb2", ptb_q, 32'h0000_2000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule